// File: doc/BRIEF.md
# Bit-Serial Halving Modular Multiplier

This block multiplies two k-bit operands modulo an odd modulus. It works one multiplier bit per clock and folds the reduction into the same step. Each step adds the multiplicand to a running sum when the current multiplier bit is set. It then makes the sum even by adding the modulus when needed, and halves it. After k such steps the sum is congruent to y·z·2^(-k) mod n. One conditional subtraction then brings it into the range [0, n).

A caller presents `yIn`, `zIn` and `nIn` together with a single-cycle `start`. The block captures all three operands at that edge, so the input buses are free for the rest of the operation. When `done` pulses, `result` holds the reduced product. `result` then stays unchanged until the next operation completes. The block serves as the inner multiplier of a modular exponentiation engine. Moving values into and out of the 2^k-scaled domain is the caller's job.

Top module: `serial_modmul`

## Requirements
- R1: For an odd `nIn`, `yIn` < `nIn` and any k-bit `zIn`, `result` equals y·z·2^(-k) mod n when `done` pulses.
- R2: `result` is always strictly below the captured modulus when `done` pulses.
- R3: The internal (k+2)-bit accumulator stays below 2n during every step and never overflows.
- R4: `done` is high for exactly one cycle. It is first seen k+1 cycles after the cycle in which `start` was presented.
- R5: Operands are captured only in the accepting `start` cycle. Changing `yIn`, `zIn` or `nIn` while an operation runs has no effect on its result.
- R6: A `start` raised while an operation is running is ignored. The running operation finishes with its own result and latency.
- R7: After reset, `done` is 0 and `result` is 0.
- R8: `result` holds its value between completions.
- R9: The accumulator is cleared on every accepted `start`, so back-to-back operations do not influence each other.
- R10: A zero multiplier, or a zero multiplicand, yields a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| yIn | input | WIDTH | Multiplicand, must be below `nIn` |
| zIn | input | WIDTH | Multiplier, consumed least significant bit first |
| nIn | input | WIDTH | Odd modulus |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Reduced product, held until the next completion |

## Verification
The in-RTL assertions watch three things on every cycle: that the accumulator stays below twice the modulus during the steps, that each completed result is below the modulus, and that `done` never lasts longer than one cycle. They also check that the result register moves only on a completion, and that a request arriving mid-operation leaves the control busy. Whether the value is actually y·z·2^(-k) mod n, and whether the latency is exactly k+1, can only be shown by the bench's scenarios. The same holds for operand capture that ignores later bus changes and for independence between consecutive operations. The bench compares each outcome against an inverse-power computation of its own.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // Strobes from the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic load;    // capture operands, clear accumulator
    logic step;    // perform one add/halve iteration
    logic finish;  // this step is the last; register the reduced result
  } mm_strobe_t;
endpackage

// File: rtl/mm_step.sv
// One combinational iteration: add y when the multiplier bit is set,
// make the sum even by adding n, then halve.
module mm_step #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH+1:0] accIn,
  input  logic [WIDTH-1:0] yVal,
  input  logic [WIDTH-1:0] nVal,
  input  logic             zBit,
  output logic [WIDTH+1:0] accOut
);
  localparam int ACC_W = WIDTH + 2;

  logic [ACC_W-1:0] partial;
  logic [ACC_W-1:0] evened;

  always_comb begin
    partial = accIn + (zBit ? ACC_W'(yVal) : ACC_W'(0));
    evened  = partial + (partial[0] ? ACC_W'(nVal) : ACC_W'(0));
    accOut  = {1'b0, evened[ACC_W-1:1]};
  end
endmodule

// File: rtl/mm_reduce.sv
// Final conditional subtraction bringing a value below 2n into [0, n).
module mm_reduce #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH+1:0] accIn,
  input  logic [WIDTH-1:0] nVal,
  output logic [WIDTH-1:0] reduced
);
  localparam int ACC_W = WIDTH + 2;

  logic [ACC_W-1:0] diff;
  logic             geMod;

  always_comb begin
    geMod   = accIn >= ACC_W'(nVal);
    diff    = accIn - ACC_W'(nVal);
    reduced = geMod ? diff[WIDTH-1:0] : accIn[WIDTH-1:0];
  end
endmodule

// File: rtl/mm_ctrl.sv
// Sequencer: accepts a start when idle, issues WIDTH steps, flags the last.
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mm_strobe_t strobes,
  output logic       done
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  logic             busy;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobes.load   = start && !busy;
    strobes.step   = busy;
    strobes.finish = busy && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
        if (strobes.finish) busy <= 1'b0;
      end
    end
  end

  // R4: completion flag is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: the step counter never passes the final iteration
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> stepCnt <= LAST_STEP);

  // R6: a request during a non-final step does not stop the running operation
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !strobes.finish) |=> busy);
endmodule

// File: rtl/mm_datapath.sv
// Operand registers, accumulator and result register.
module mm_datapath
  import mm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  mm_strobe_t       strobes,
  input  logic [WIDTH-1:0] yIn,
  input  logic [WIDTH-1:0] zIn,
  input  logic [WIDTH-1:0] nIn,
  output logic [WIDTH-1:0] result
);
  localparam int ACC_W = WIDTH + 2;

  logic [WIDTH-1:0] yReg;
  logic [WIDTH-1:0] zReg;
  logic [WIDTH-1:0] nReg;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [WIDTH-1:0] reducedNext;

  mm_step #(.WIDTH(WIDTH)) uStep (
    .accIn (acc),
    .yVal  (yReg),
    .nVal  (nReg),
    .zBit  (zReg[0]),
    .accOut(accNext)
  );

  mm_reduce #(.WIDTH(WIDTH)) uReduce (
    .accIn  (accNext),
    .nVal   (nReg),
    .reduced(reducedNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yReg   <= '0;
      zReg   <= '0;
      nReg   <= '0;
      acc    <= '0;
      result <= '0;
    end else begin
      if (strobes.load) begin
        yReg <= yIn;
        zReg <= zIn;
        nReg <= nIn;
        acc  <= '0;
      end else if (strobes.step) begin
        zReg <= zReg >> 1;
        acc  <= accNext;
      end
      if (strobes.finish) result <= reducedNext;
    end
  end

  // R3: with reduced operands the accumulator stays below twice the modulus
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && nReg[0] && (yReg < nReg)) |-> (acc < {1'b0, nReg, 1'b0}));

  // R2: each registered result lies below the captured modulus
  assert_result_below_mod_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && nReg[0] && (yReg < nReg)) |=> (result < nReg));

  // R8: the result register changes only on a completion
  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> $stable(result));
endmodule

// File: rtl/serial_modmul.sv
// Top: bit-serial halving modular multiplier.
module serial_modmul
  import mm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] yIn,
  input  logic [WIDTH-1:0] zIn,
  input  logic [WIDTH-1:0] nIn,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  mm_strobe_t strobes;

  mm_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .done   (done)
  );

  mm_datapath #(.WIDTH(WIDTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .yIn    (yIn),
    .zIn    (zIn),
    .nIn    (nIn),
    .result (result)
  );
endmodule

// File: tb/tb_serial_modmul.sv
module tb_serial_modmul;
  localparam int W = 16;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [W-1:0] y;
    logic [W-1:0] z;
    logic [W-1:0] n;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{y: 16'd3,     z: 16'd5,     n: 16'd13},
    '{y: 16'd12,    z: 16'd12,    n: 16'd13},
    '{y: 16'd1000,  z: 16'd2000,  n: 16'd40961},
    '{y: 16'd65534, z: 16'd65535, n: 16'd65535},
    '{y: 16'd1,     z: 16'd1,     n: 16'd65521},
    '{y: 16'd30000, z: 16'd45678, n: 16'd54321},
    '{y: 16'd0,     z: 16'hFFFF,  n: 16'd1},
    '{y: 16'd777,   z: 16'h8001,  n: 16'd1009}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] yIn = '0, zIn = '0, nIn = '0;
  logic done;
  logic [W-1:0] result;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  serial_modmul #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .yIn(yIn), .zIn(zIn), .nIn(nIn),
    .done(done), .result(result)
  );

  // Reference: reduce y*z, then multiply by the inverse of 2^W modulo n.
  function automatic longint refMul(longint y, longint z, longint n);
    longint half = (n + 1) / 2;
    longint inv = 1 % n;
    for (int i = 0; i < W; i++) inv = (inv * half) % n;
    return (((y * z) % n) * inv) % n;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Presents start for one cycle, returns latency in cycles (0 on timeout).
  task automatic runOp(input logic [W-1:0] y, input logic [W-1:0] z,
                       input logic [W-1:0] n, output int lat);
    @(negedge clk);
    yIn = y; zIn = z; nIn = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int c = 1; c < 100; c++) begin
      if (done) begin lat = c; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat;
    logic [W-1:0] held;
    longint exp;

    repeat (2) @(negedge clk);
    // R7: reset state
    check(done == 1'b0, "R7 done", done, 0);
    check(result == '0, "R7 result", result, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R9 R10: table of vectors, run back to back
    for (int v = 0; v < NVEC; v++) begin
      runOp(VECS[v].y, VECS[v].z, VECS[v].n, lat);
      exp = refMul(VECS[v].y, VECS[v].z, VECS[v].n);
      check(lat == W + 1, "R4 latency", lat, W + 1);
      check(result == exp, "R1/R9 value", result, exp);
      check(result < VECS[v].n, "R2 below modulus", result, VECS[v].n);
      @(negedge clk);
      check(done == 1'b0, "R4 single pulse", done, 0);
    end

    // R10: zero multiplier
    runOp(16'd500, 16'd0, 16'd1009, lat);
    check(result == 0, "R10 zero multiplier", result, 0);
    // R10: zero multiplicand
    runOp(16'd0, 16'd4321, 16'd1009, lat);
    check(result == 0, "R10 zero multiplicand", result, 0);

    // R5: change buses during the operation
    @(negedge clk);
    yIn = 16'd123; zIn = 16'd456; nIn = 16'd997; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    yIn = 16'd900; zIn = 16'hFFFF; nIn = 16'd65521;
    lat = 0;
    for (int c = 1; c < 100; c++) begin
      if (done) begin lat = c; break; end
      @(negedge clk);
    end
    exp = refMul(123, 456, 997);
    check(result == exp, "R5 captured operands", result, exp);
    check(lat == W + 1, "R5 latency", lat, W + 1);

    // R6: start during an operation is ignored
    @(negedge clk);
    yIn = 16'd40; zIn = 16'd77; nIn = 16'd101; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int c = 1; c < 100; c++) begin
      if (c == 4) begin
        yIn = 16'd5; zIn = 16'd9; nIn = 16'd11; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) begin lat = c; break; end
      @(negedge clk);
    end
    start = 1'b0;
    exp = refMul(40, 77, 101);
    check(result == exp, "R6 running result kept", result, exp);
    check(lat == W + 1, "R6 latency unchanged", lat, W + 1);

    // R8: result held while idle with changing inputs
    held = result;
    yIn = 16'd1; zIn = 16'd2; nIn = 16'd3;
    repeat (6) @(negedge clk);
    check(result == held, "R8 result held", result, held);
    check(done == 1'b0, "R8 no spurious done", done, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule